// File: doc/BRIEF.md
# Dual Timer-Paced Sample Queue

This block holds two independent queues of signed 8-bit audio samples, channel A and channel B, placed between a processor write port and a sound mixer. Software (or a DMA engine acting for it) pushes bytes into either queue through a small byte-addressed write port. Each queue is emptied one sample at a time, paced by the overflow strobe of one of two hardware timers. Each channel picks its timer with its own select bit in a control word.

On every drain event the head sample of a channel moves into that channel's output latch. The latch holds the value the mixer hears until the next drain. A drain on an empty queue does not stall: it silences the channel by latching zero. After any overflow of either timer, each channel whose queue has fallen below half full raises a one-cycle refill request toward its DMA channel. A combined amplitude, the floored mean of the two latches, is offered alongside the two individual samples.

Top module: `sample_queue_pair`

## Requirements
- R1: After reset both sample latches and the combined amplitude read 0, no refill request is raised, both queues are empty, and both channels are paced by timer 0.
- R2: A write with `wrEn` high stores `wrData` at the tail of the queue chosen by `wrAddr[2]` (0 is channel A, 1 is channel B). Bits 1:0 of the address are ignored. Each queue returns its samples in the order they were written.
- R3: Each queue holds 32 samples. A write to a full queue is discarded, the occupancy stays at 32, and the stored contents are unchanged.
- R4: When `ctrlWe` is high, `ctrlWord[10]` selects channel A's timer and `ctrlWord[14]` selects channel B's timer (0 is timer 0, 1 is timer 1). The selection takes effect from the next cycle. A channel drains only on an overflow of its selected timer.
- R5: A drain on a non-empty queue copies the head sample into that channel's latch, visible after the clock edge. It advances the read position modulo 32 and lowers the occupancy by one, so draining works across the wrap of the circular store.
- R6: A drain on an empty queue sets that channel's latch to 0.
- R7: At a clock edge where `timerOvf` is non-zero, `dmaReqA` / `dmaReqB` is high for the following cycle exactly when that channel's occupancy after the edge is below 16. Otherwise the request is low.
- R8: `mixOut` equals floor((sampleA + sampleB) / 2) with both samples taken as signed values.
- R9: When `ctrlWe` is high, `ctrlWord[11]` empties queue A and `ctrlWord[15]` empties queue B. The clear wins over a write or drain on the same channel in that cycle and leaves the latch as it was. The clear bits are strobes and are not stored.
- R10: A write and a drain on the same channel in the same cycle both take effect, and the occupancy is unchanged. On an empty queue the drain latches 0 and the written sample is kept (occupancy 1). On a full queue the drain proceeds and the write is discarded (occupancy 31).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Byte write strobe |
| wrAddr | input | 3 | Byte write address; bit 2 picks the channel |
| wrData | input | 8 | Sample byte to store |
| timerOvf | input | 2 | Overflow strobes of timer 0 (bit 0) and timer 1 (bit 1) |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlWord | input | 16 | Control word: timer selects (bits 10, 14), queue clears (bits 11, 15) |
| sampleA | output | 8 | Latched signed sample of channel A |
| sampleB | output | 8 | Latched signed sample of channel B |
| mixOut | output | 8 | Floored signed mean of the two latches |
| dmaReqA | output | 1 | One-cycle refill request for channel A |
| dmaReqB | output | 1 | One-cycle refill request for channel B |

## Verification
The first pattern fills queue A past capacity and drains it through the 32-slot wrap. This separates a correct modulo pointer and a dropped overflow write from an off-by-one occupancy. The second pattern runs each timer select against each timer strobe, which shows whether a channel follows its own selection rather than the other channel's. A paired sweep of signed sample values through both queues exercises the rounding of the mean at negative and odd sums. Collisions of write with drain, and of clear with both, are applied at empty, partly filled and full occupancy. These cases separate the priority rules, and the refill request is compared on every cycle as the occupancy crosses 16.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int unsigned N_CH = 2;

  // Per-channel strobes from control to datapath
  typedef struct packed {
    logic push;   // accepted write
    logic pop;    // drain with data present
    logic zero;   // drain on empty queue
    logic clear;  // empty the queue
    logic check;  // timer event: evaluate refill request
  } chStrobe_t;
endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [1:0]                     timerOvf,
  input  logic                           ctrlWe,
  input  logic [15:0]                    ctrlWord,
  input  logic [N_CH-1:0][CNT_W-1:0]     occ,
  output chStrobe_t [N_CH-1:0]           strobe,
  output logic [N_CH-1:0]                timerSel
);
  localparam int unsigned CH_BIT = 2;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam int unsigned SEL_POS = 10 + 4 * ch;
    localparam int unsigned CLR_POS = 11 + 4 * ch;

    logic hitWr, hitOvf, isEmpty, isFull, doClear;

    always_ff @(posedge clk) begin
      if (!rstN) timerSel[ch] <= 1'b0;
      else if (ctrlWe) timerSel[ch] <= ctrlWord[SEL_POS];
    end

    always_comb begin
      hitWr   = wrEn && (wrAddr[CH_BIT] == 1'(ch));
      hitOvf  = timerOvf[timerSel[ch]];
      isEmpty = (occ[ch] == '0);
      isFull  = (occ[ch] == CNT_W'(DEPTH));
      doClear = ctrlWe && ctrlWord[CLR_POS];
      strobe[ch].clear = doClear;
      strobe[ch].push  = hitWr && !isFull && !doClear;
      strobe[ch].pop   = hitOvf && !isEmpty && !doClear;
      strobe[ch].zero  = hitOvf && isEmpty && !doClear;
      strobe[ch].check = |timerOvf;
    end
  end
endmodule

// File: rtl/sq_datapath.sv
module sq_datapath
  import sq_pkg::*;
#(
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LOW_MARK = 16,
  parameter int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  chStrobe_t [N_CH-1:0]           strobe,
  input  logic [DATA_W-1:0]              wrData,
  output logic [N_CH-1:0][DATA_W-1:0]    sample,
  output logic [N_CH-1:0][CNT_W-1:0]     occ,
  output logic [N_CH-1:0]                dmaReq
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  rdPtr;
    logic [PTR_W-1:0]  wrPtr;
    logic [CNT_W-1:0]  occNext;

    always_comb begin
      wrPtr = rdPtr + occ[ch][PTR_W-1:0];
      if (strobe[ch].clear) occNext = '0;
      else occNext = occ[ch] + CNT_W'(strobe[ch].push) - CNT_W'(strobe[ch].pop);
    end

    always_ff @(posedge clk) begin
      if (strobe[ch].push) store[wrPtr] <= wrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdPtr      <= '0;
        occ[ch]    <= '0;
        sample[ch] <= '0;
        dmaReq[ch] <= 1'b0;
      end else begin
        occ[ch]    <= occNext;
        dmaReq[ch] <= strobe[ch].check && (occNext < CNT_W'(LOW_MARK));
        if (strobe[ch].clear) rdPtr <= '0;
        else if (strobe[ch].pop) rdPtr <= rdPtr + 1'b1;
        if (strobe[ch].pop) sample[ch] <= store[rdPtr];
        else if (strobe[ch].zero) sample[ch] <= '0;
      end
    end
  end
endmodule

// File: rtl/sample_queue_pair.sv
module sample_queue_pair
  import sq_pkg::*;
#(
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LOW_MARK = 16,
  parameter int unsigned ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        timerOvf,
  input  logic              ctrlWe,
  input  logic [15:0]       ctrlWord,
  output logic [DATA_W-1:0] sampleA,
  output logic [DATA_W-1:0] sampleB,
  output logic [DATA_W-1:0] mixOut,
  output logic              dmaReqA,
  output logic              dmaReqB
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  chStrobe_t [N_CH-1:0]        strobe;
  logic [N_CH-1:0][CNT_W-1:0]  occ;
  logic [N_CH-1:0][DATA_W-1:0] sample;
  logic [N_CH-1:0]             dmaReq;
  logic [N_CH-1:0]             timerSel;
  logic [DATA_W:0]             mixSum;

  sq_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .timerOvf(timerOvf),
    .ctrlWe(ctrlWe), .ctrlWord(ctrlWord), .occ(occ), .strobe(strobe),
    .timerSel(timerSel)
  );

  sq_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LOW_MARK(LOW_MARK), .CNT_W(CNT_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .sample(sample), .occ(occ), .dmaReq(dmaReq)
  );

  assign mixSum  = {sample[0][DATA_W-1], sample[0]} + {sample[1][DATA_W-1], sample[1]};
  assign mixOut  = mixSum[DATA_W:1];
  assign sampleA = sample[0];
  assign sampleB = sample[1];
  assign dmaReqA = dmaReq[0];
  assign dmaReqB = dmaReq[1];
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [2:0]        wrAddr,
  input logic [1:0]        timerOvf,
  input logic              ctrlWe,
  input logic [15:0]       ctrlWord,
  input logic [CNT_W-1:0]  occA,
  input logic              selA,
  input logic [DATA_W-1:0] sampleA,
  input logic              dmaReqA,
  input logic              dmaReqB
);
  logic clrA;
  assign clrA = ctrlWe && ctrlWord[11];

  p_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    occA <= CNT_W'(DEPTH));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (occA == CNT_W'(DEPTH) && wrEn && !wrAddr[2] && timerOvf == 2'b00 && !clrA)
    |=> occA == CNT_W'(DEPTH));

  p_drain_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (timerOvf[selA] && occA != '0 && !wrEn && !clrA)
    |=> occA == $past(occA) - 1'b1);

  p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (timerOvf[selA] && occA == '0 && !clrA) |=> sampleA == '0);

  p_req_after_ovf_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReqA || dmaReqB) |-> $past(timerOvf) != 2'b00);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    clrA |=> occA == '0);

  p_collide_r10: assert property (@(posedge clk) disable iff (!rstN)
    (timerOvf[selA] && wrEn && !wrAddr[2] && !clrA && occA != '0 && occA != CNT_W'(DEPTH))
    |=> $stable(occA));
endmodule

bind sample_queue_pair sq_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .timerOvf(timerOvf),
  .ctrlWe(ctrlWe), .ctrlWord(ctrlWord), .occA(occ[0]), .selA(timerSel[0]),
  .sampleA(sampleA), .dmaReqA(dmaReqA), .dmaReqB(dmaReqB)
);

// File: tb/test_sample_queue_pair.sv
module test_sample_queue_pair;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [2:0]  wrAddr;
  logic [7:0]  wrData;
  logic [1:0]  timerOvf;
  logic        ctrlWe;
  logic [15:0] ctrlWord;
  logic [7:0]  sampleA, sampleB, mixOut;
  logic        dmaReqA, dmaReqB;

  sample_queue_pair i_sample_queue_pair (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timerOvf(timerOvf), .ctrlWe(ctrlWe), .ctrlWord(ctrlWord),
    .sampleA(sampleA), .sampleB(sampleB), .mixOut(mixOut),
    .dmaReqA(dmaReqA), .dmaReqB(dmaReqB)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    nCmp = 0, nBad = 0;
  bit    done = 0;
  string tag = "R1";

  // Reference model
  int mq [2][32];
  int rp [2], cn [2], lat [2], sel [2], req [2];

  task automatic expect_val(input string what, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int s;
    s = lat[0] + lat[1];
    expect_val("sampleA", int'($signed(sampleA)), lat[0]);
    expect_val("sampleB", int'($signed(sampleB)), lat[1]);
    expect_val("mixOut", int'($signed(mixOut)), s >>> 1);
    expect_val("dmaReqA", int'(dmaReqA), req[0]);
    expect_val("dmaReqB", int'(dmaReqB), req[1]);
  endtask

  task automatic step(input logic w, input logic [2:0] a, input logic [7:0] d,
                      input logic [1:0] ov, input logic cw, input logic [15:0] cword);
    @(negedge clk);
    wrEn = w; wrAddr = a; wrData = d; timerOvf = ov; ctrlWe = cw; ctrlWord = cword;
    @(posedge clk);
    for (int ch = 0; ch < 2; ch++) begin
      bit pop, push, clr;
      int oldRp, oldCn;
      pop  = ov[sel[ch]];
      push = w && (int'(a[2]) == ch);
      clr  = cw && cword[11 + 4 * ch];
      oldRp = rp[ch]; oldCn = cn[ch];
      if (clr) begin
        rp[ch] = 0; cn[ch] = 0;
      end else begin
        if (pop) begin
          if (oldCn > 0) begin
            lat[ch] = mq[ch][oldRp];
            rp[ch]  = (oldRp + 1) % 32;
            cn[ch]  = cn[ch] - 1;
          end else lat[ch] = 0;
        end
        if (push && oldCn < 32) begin
          mq[ch][(oldRp + oldCn) % 32] = int'($signed(d));
          cn[ch] = cn[ch] + 1;
        end
      end
      req[ch] = (ov != 2'b00 && cn[ch] < 16) ? 1 : 0;
    end
    if (cw) begin sel[0] = cword[10]; sel[1] = cword[14]; end
    #1;
    compare_all();
  endtask

  task automatic idle();
    step(1'b0, 3'd0, 8'd0, 2'b00, 1'b0, 16'h0000);
  endtask

  task automatic push_byte(input int ch, input int addrLow, input int val);
    step(1'b1, {ch[0], addrLow[1:0]}, val[7:0], 2'b00, 1'b0, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nBad++; nCmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    for (int ch = 0; ch < 2; ch++) begin
      rp[ch] = 0; cn[ch] = 0; lat[ch] = 0; sel[ch] = 0; req[ch] = 0;
    end
    rstN = 1'b0; wrEn = 0; wrAddr = 0; wrData = 0; timerOvf = 0; ctrlWe = 0; ctrlWord = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1: reset state
    tag = "R1";
    #1 compare_all();
    idle();

    // R2: channel by address bit 2, low bits ignored, FIFO order
    tag = "R2";
    for (int i = 0; i < 5; i++) push_byte(0, i, 10 + i);
    for (int i = 0; i < 3; i++) push_byte(1, i + 1, -20 - i);

    // R4 / R7: both on timer 0; timer 1 must not drain, but raises requests
    tag = "R4";
    step(1'b0, 3'd0, 8'd0, 2'b10, 1'b0, 16'h0000);
    step(1'b0, 3'd0, 8'd0, 2'b01, 1'b0, 16'h0000);
    // A on timer 1, B stays on timer 0
    step(1'b0, 3'd0, 8'd0, 2'b00, 1'b1, 16'h0400);
    step(1'b0, 3'd0, 8'd0, 2'b10, 1'b0, 16'h0000);
    step(1'b0, 3'd0, 8'd0, 2'b01, 1'b0, 16'h0000);
    // swap: A timer 0, B timer 1
    step(1'b0, 3'd0, 8'd0, 2'b00, 1'b1, 16'h4000);
    step(1'b0, 3'd0, 8'd0, 2'b10, 1'b0, 16'h0000);
    step(1'b0, 3'd0, 8'd0, 2'b01, 1'b0, 16'h0000);

    // R5 / R6: drain both to empty and beyond
    tag = "R6";
    for (int i = 0; i < 6; i++) step(1'b0, 3'd0, 8'd0, 2'b11, 1'b0, 16'h0000);
    step(1'b0, 3'd0, 8'd0, 2'b00, 1'b1, 16'h0000);

    // R3: overfill A (read pointer is mid-store, so the wrap is crossed)
    tag = "R3";
    for (int i = 0; i < 34; i++) push_byte(0, i, i * 7 - 100);
    // R5 / R7: drain all 32 across the wrap, requests as occupancy crosses 16
    tag = "R5";
    for (int i = 0; i < 33; i++) step(1'b0, 3'd0, 8'd0, 2'b01, 1'b0, 16'h0000);

    // R8: paired sweep of signed values
    tag = "R8";
    for (int round = 0; round < 4; round++) begin
      for (int k = 0; k < 32; k++) begin
        int va, vb;
        va = ((k * 37 + round * 61) % 256) - 128;
        vb = ((k * 91 + round * 13 + 5) % 256) - 128;
        push_byte(0, k, va);
        push_byte(1, k, vb);
      end
      for (int k = 0; k < 32; k++) step(1'b0, 3'd0, 8'd0, 2'b01, 1'b0, 16'h0000);
    end

    // R10: write plus drain collisions at empty, mid and full
    tag = "R10";
    step(1'b1, 3'd0, 8'd55, 2'b01, 1'b0, 16'h0000);
    for (int i = 0; i < 5; i++) push_byte(0, i, 60 + i);
    for (int i = 0; i < 4; i++) step(1'b1, 3'd1, 8'(70 + i), 2'b01, 1'b0, 16'h0000);
    for (int i = 0; i < 30; i++) push_byte(0, i, -50 + i);
    step(1'b1, 3'd2, 8'd99, 2'b01, 1'b0, 16'h0000);
    for (int i = 0; i < 33; i++) step(1'b0, 3'd0, 8'd0, 2'b01, 1'b0, 16'h0000);

    // R9: clear wins over same-cycle write and drain, latch kept, not stored
    tag = "R9";
    for (int i = 0; i < 6; i++) push_byte(0, i, 30 + i);
    for (int i = 0; i < 6; i++) push_byte(1, i, -30 - i);
    step(1'b0, 3'd0, 8'd0, 2'b01, 1'b0, 16'h0000);
    step(1'b1, 3'd0, 8'd77, 2'b01, 1'b1, 16'h0800);
    step(1'b0, 3'd0, 8'd0, 2'b01, 1'b0, 16'h0000);
    step(1'b0, 3'd0, 8'd0, 2'b01, 1'b1, 16'h8000);
    step(1'b0, 3'd0, 8'd0, 2'b01, 1'b0, 16'h0000);
    push_byte(0, 0, 12);
    step(1'b0, 3'd0, 8'd0, 2'b01, 1'b0, 16'h0000);
    idle();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule